// File: doc/BRIEF.md
# DDR DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and owns the command pins from reset until the memory is ready for normal traffic. After a synchronous reset it holds the clock enable low through a configurable stabilization interval. It then raises the clock enable and walks the memory through a fixed bring-up order: precharge of all banks, extended mode set with the DLL enabled, mode set with the DLL-reset bit, a DLL lock wait, a second precharge of all banks, a configurable number of auto-refresh commands (never fewer than two), and a final mode set with the DLL-reset bit cleared. When the last mode-set cycle time has passed, it raises `init_done`, which tells the main controller that it may take over.

Every gap between commands is a parameter counted in clock cycles. The final mode word (burst length, burst type and read latency in address bits 6..0) and the output driver strength come in on input ports. These inputs and `num_aref` must stay stable while the sequence runs. All pin outputs are registered.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset is released, `cke` stays low for exactly STAB_CYC cycles and rises on edge STAB_CYC. While `cke` is low, the command pins carry a no-operation ({cs_n,ras_n,cas_n,we_n} = 0111).
- R2: The commands appear in this order: precharge-all (0010) one cycle after `cke` rises, then extended mode set (0000, ba=1), then mode set (0000, ba=0) with the DLL-reset bit.
- R3: The next command follows TRP_CYC cycles after each precharge. It follows TMRD_CYC cycles after the extended mode set and after the final mode set.
- R4: After the DLL-reset mode set, the second precharge-all comes max(TMRD_CYC, DLL_LOCK_CYC) cycles later.
- R5: After the second precharge, max(2, `num_aref`) auto-refresh commands (0001) are issued, spaced TRFC_CYC cycles apart. The final mode set comes TRFC_CYC cycles after the last one.
- R6: The extended mode set drives address bit 0 low (DLL enabled). Bit 1 and bit 6 carry `drive_sel[0]` and `drive_sel[1]`; the unusable code 2'b10 is replaced by 2'b00 (full strength). All other address bits are 0.
- R7: The DLL-reset mode set drives `mode_cfg` on address bits 6..0, bit 8 high, bit 7 (test mode) low, and all higher bits 0.
- R8: The final mode set drives `mode_cfg` on bits 6..0, with bits 7 and 8 low and all higher bits 0.
- R9: Both precharge commands drive address bit 8 high (all banks), with all other address bits and `ba` at 0.
- R10: Every cycle with `cke` high that is not one of the commands above is a no-operation with the address and `ba` at 0.
- R11: `init_done` is low until TMRD_CYC cycles after the final mode set. It then rises and stays high until reset, while the pins keep driving no-operation.
- R12: Reset, at any point, returns the block to its start state: on the next cycle `cke` and `init_done` are low and the pins carry a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | 7 | Mode word bits 6..0 for both mode sets |
| drive_sel | input | 2 | Driver strength code {bit6, bit1} for the extended mode set |
| num_aref | input | REF_W | Requested auto-refresh count (minimum 2 enforced) |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address / mode opcode bus |
| ba | output | BA_W | Bank select / mode register select |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
A wrong state register or wrong gap counter shows at the pins in the very cycle the misplaced command would appear. A step skipped or repeated shifts every later command, so the cycle-by-cycle comparison against the schedule computed from the parameters catches it at the first displaced command. A fault in the refresh counter moves the final mode set and `init_done` by a whole multiple of TRFC_CYC. A wrong opcode field is visible on the address bus in the single cycle of the mode or extended-mode set.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_STAB,
    ST_PRE1,
    ST_EMRS,
    ST_MRS_DLL,
    ST_PRE2,
    ST_AREF,
    ST_MRS_FIN,
    ST_FIN,
    ST_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_PRE,
    OP_AREF,
    OP_MRS_DLL,
    OP_MRS_NORM,
    OP_EMRS
  } seq_op_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam int ALLBANK_BIT = 8;
  localparam int DLLRST_BIT  = 8;
  localparam int TESTM_BIT   = 7;

  localparam cmd_pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t PINS_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_pins_t PINS_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_pins_t PINS_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] rst_val,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= rst_val;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: the gap counter only ever steps down by one while waiting
  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ddr_init_aref_cnt.sv
module ddr_init_aref_cnt #(
  parameter int REF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REF_W-1:0] num_aref,
  input  logic             issue,
  output logic             last
);

  localparam int TW = REF_W + 1;

  logic [REF_W-1:0] issued;
  logic [TW-1:0]    target;

  always_comb begin
    if (num_aref < REF_W'(2)) target = TW'(2);
    else                      target = {1'b0, num_aref};
  end

  assign last = ({1'b0, issued} + TW'(1)) >= target;

  always_ff @(posedge clk) begin
    if (rst)        issued <= '0;
    else if (issue) issued <= issued + 1'b1;
  end

  // R5: a refresh is never issued beyond the effective target
  a_r5_within_target: assert property (@(posedge clk) disable iff (rst)
    issue |-> ({1'b0, issued} < target));

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  seq_op_t           op,
  input  logic [6:0]        mode_cfg,
  input  logic [1:0]        drive_sel,
  output cmd_pins_t         pins,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);

  logic [1:0] drv_eff;

  assign drv_eff = (drive_sel == 2'b10) ? 2'b00 : drive_sel;

  always_comb begin
    pins = PINS_NOP;
    addr = '0;
    ba   = '0;
    unique case (op)
      OP_PRE: begin
        pins              = PINS_PRE;
        addr[ALLBANK_BIT] = 1'b1;
      end
      OP_AREF: pins = PINS_AREF;
      OP_EMRS: begin
        pins    = PINS_MODE;
        ba      = BA_W'(1);
        addr[0] = 1'b0;
        addr[1] = drv_eff[0];
        addr[6] = drv_eff[1];
      end
      OP_MRS_DLL: begin
        pins             = PINS_MODE;
        addr[6:0]        = mode_cfg;
        addr[DLLRST_BIT] = 1'b1;
      end
      OP_MRS_NORM: begin
        pins      = PINS_MODE;
        addr[6:0] = mode_cfg;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2,
  parameter int STAB_CYC     = 25000,
  parameter int TRP_CYC      = 3,
  parameter int TMRD_CYC     = 2,
  parameter int TRFC_CYC     = 10,
  parameter int DLL_LOCK_CYC = 200,
  parameter int REF_W        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        mode_cfg,
  input  logic [1:0]        drive_sel,
  input  logic [REF_W-1:0]  num_aref,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done
);

  localparam int LOCK_GAP = (DLL_LOCK_CYC > TMRD_CYC) ? DLL_LOCK_CYC : TMRD_CYC;
  localparam int M1   = (STAB_CYC > LOCK_GAP) ? STAB_CYC : LOCK_GAP;
  localparam int M2   = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
  localparam int MAXV = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXV + 1);

  localparam logic [CW-1:0] G_STAB = CW'(STAB_CYC - 1);
  localparam logic [CW-1:0] G_RP   = CW'(TRP_CYC - 1);
  localparam logic [CW-1:0] G_MRD  = CW'(TMRD_CYC - 1);
  localparam logic [CW-1:0] G_RFC  = CW'(TRFC_CYC - 1);
  localparam logic [CW-1:0] G_LOCK = CW'(LOCK_GAP - 1);

  seq_state_t        state, nxt_state;
  seq_op_t           nxt_op;
  logic [CW-1:0]     load_val;
  logic              tmr_expired, step;
  logic              raise_cke, set_done, aref_issue, aref_last;
  cmd_pins_t         enc_pins, pins_q;
  logic [ADDR_W-1:0] enc_addr, addr_q;
  logic [BA_W-1:0]   enc_ba, ba_q;
  logic              cke_q, done_q;

  assign step = tmr_expired && (state != ST_DONE);

  ddr_init_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .rst_val  (G_STAB),
    .load     (step),
    .load_val (load_val),
    .expired  (tmr_expired)
  );

  ddr_init_aref_cnt #(.REF_W(REF_W)) u_aref (
    .clk      (clk),
    .rst      (rst),
    .num_aref (num_aref),
    .issue    (aref_issue),
    .last     (aref_last)
  );

  always_comb begin
    nxt_state  = state;
    nxt_op     = OP_NOP;
    load_val   = '0;
    raise_cke  = 1'b0;
    set_done   = 1'b0;
    aref_issue = 1'b0;
    if (step) begin
      unique case (state)
        ST_STAB: begin
          raise_cke = 1'b1;
          nxt_state = ST_PRE1;
        end
        ST_PRE1: begin
          nxt_op    = OP_PRE;
          load_val  = G_RP;
          nxt_state = ST_EMRS;
        end
        ST_EMRS: begin
          nxt_op    = OP_EMRS;
          load_val  = G_MRD;
          nxt_state = ST_MRS_DLL;
        end
        ST_MRS_DLL: begin
          nxt_op    = OP_MRS_DLL;
          load_val  = G_LOCK;
          nxt_state = ST_PRE2;
        end
        ST_PRE2: begin
          nxt_op    = OP_PRE;
          load_val  = G_RP;
          nxt_state = ST_AREF;
        end
        ST_AREF: begin
          nxt_op     = OP_AREF;
          load_val   = G_RFC;
          aref_issue = 1'b1;
          nxt_state  = aref_last ? ST_MRS_FIN : ST_AREF;
        end
        ST_MRS_FIN: begin
          nxt_op    = OP_MRS_NORM;
          load_val  = G_MRD;
          nxt_state = ST_FIN;
        end
        ST_FIN: begin
          set_done  = 1'b1;
          nxt_state = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  ddr_init_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .op        (nxt_op),
    .mode_cfg  (mode_cfg),
    .drive_sel (drive_sel),
    .pins      (enc_pins),
    .addr      (enc_addr),
    .ba        (enc_ba)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_STAB;
      cke_q  <= 1'b0;
      pins_q <= PINS_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      done_q <= 1'b0;
    end else begin
      state  <= nxt_state;
      pins_q <= enc_pins;
      addr_q <= enc_addr;
      ba_q   <= enc_ba;
      if (raise_cke) cke_q  <= 1'b1;
      if (set_done)  done_q <= 1'b1;
    end
  end

  assign cke       = cke_q;
  assign cs_n      = pins_q.cs_n;
  assign ras_n     = pins_q.ras_n;
  assign cas_n     = pins_q.cas_n;
  assign we_n      = pins_q.we_n;
  assign addr      = addr_q;
  assign ba        = ba_q;
  assign init_done = done_q;

  // R1: no command other than no-operation while the clock enable is low
  a_r1_cke_low_nop: assert property (@(posedge clk) disable iff (rst)
    !cke |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

  // R6: extended mode set keeps the DLL enabled and never drives code 10
  a_r6_emrs_fields: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0000 && ba == BA_W'(1)) |->
      (!addr[0] && !(addr[6] && !addr[1])));

  // R7 / R8: mode sets keep test mode and upper bits at zero
  a_r7_mrs_reserved: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0000 && ba == '0) |->
      (!addr[TESTM_BIT] && (addr >> (DLLRST_BIT + 1)) == '0));

  // R9: precharge always addresses all banks
  a_r9_pre_all: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> addr[ALLBANK_BIT]);

  // R11: completion flag is sticky and follows the clock enable
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  a_r11_done_cke: assert property (@(posedge clk) disable iff (rst)
    init_done |-> cke);

  // R12: reset returns to the start state on the next cycle
  a_r12_reset_state: assert property (@(posedge clk)
    rst |=> (!cke && !init_done && {cs_n, ras_n, cas_n, we_n} == 4'b0111));

endmodule

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;

  localparam int ADDR_W = 12;
  localparam int BA_W   = 2;
  localparam int STAB   = 40;
  localparam int TRP    = 3;
  localparam int TMRD   = 2;
  localparam int TRFC   = 7;
  localparam int DLL    = 200;
  localparam int REF_W  = 4;
  localparam int NRUN   = 6;

  // each vector: {num_aref[3:0], mode_cfg[6:0], drive_sel[1:0]}
  localparam logic [12:0] VEC [NRUN] = '{
    {4'd2, 7'b0110010, 2'b00},
    {4'd0, 7'b1000011, 2'b01},
    {4'd1, 7'b0111010, 2'b11},
    {4'd4, 7'b0101001, 2'b10},
    {4'd3, 7'b1111111, 2'b11},
    {4'd8, 7'b0000000, 2'b01}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] mode_cfg = '0;
  logic [1:0] drive_sel = '0;
  logic [REF_W-1:0] num_aref = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0] ba;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ddr_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .STAB_CYC(STAB), .TRP_CYC(TRP),
    .TMRD_CYC(TMRD), .TRFC_CYC(TRFC), .DLL_LOCK_CYC(DLL), .REF_W(REF_W)
  ) dut (
    .clk(clk), .rst(rst), .mode_cfg(mode_cfg), .drive_sel(drive_sel),
    .num_aref(num_aref), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .init_done(init_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input int t);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, t, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_case(input logic [12:0] v);
    int n, tp1, te, tm1, tp2, ta0, tmf, tdn;
    logic [3:0] ep;
    logic [ADDR_W-1:0] ea;
    logic [BA_W-1:0] eb;
    logic [1:0] drv;
    string req;
    num_aref  = v[12:9];
    mode_cfg  = v[8:2];
    drive_sel = v[1:0];
    drv = (v[1:0] == 2'b10) ? 2'b00 : v[1:0];
    n   = (v[12:9] < 2) ? 2 : int'(v[12:9]);
    tp1 = STAB + 1;
    te  = tp1 + TRP;
    tm1 = te + TMRD;
    tp2 = tm1 + ((DLL > TMRD) ? DLL : TMRD);
    ta0 = tp2 + TRP;
    tmf = ta0 + n * TRFC;
    tdn = tmf + TMRD;
    do_reset(3);
    for (int t = 1; t <= tdn + 12; t++) begin
      @(posedge clk);
      @(negedge clk);
      ep = 4'b0111; ea = '0; eb = '0; req = "R10";
      if (t < STAB) req = "R1";
      else if (t > tm1 && t < tp2) req = "R4";
      else if (t >= tdn) req = "R11";
      if (t == tp1)      begin ep = 4'b0010; ea[8] = 1'b1; req = "R2 R9"; end
      else if (t == te)  begin ep = 4'b0000; eb = 2'd1; ea[1] = drv[0]; ea[6] = drv[1]; req = "R3 R6"; end
      else if (t == tm1) begin ep = 4'b0000; ea[6:0] = v[8:2]; ea[8] = 1'b1; req = "R2 R7"; end
      else if (t == tp2) begin ep = 4'b0010; ea[8] = 1'b1; req = "R4 R9"; end
      else if (t == tmf) begin ep = 4'b0000; ea[6:0] = v[8:2]; req = "R5 R8"; end
      else if (t >= ta0 && t < tmf && ((t - ta0) % TRFC) == 0) begin ep = 4'b0001; req = "R5"; end
      check(req, {31'd0, cke}, {31'd0, (t >= STAB)}, t);
      check(req, {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, ep}, t);
      check(req, {20'd0, addr}, {20'd0, ea}, t);
      check(req, {30'd0, ba}, {30'd0, eb}, t);
      check("R11", {31'd0, init_done}, {31'd0, (t >= tdn)}, t);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    // R12: outputs held in start state during reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R12", {30'd0, cke, init_done}, 32'd0, 0);
    check("R12", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7, 0);
    for (int i = 0; i < NRUN; i++) run_case(VEC[i]);

    // R12: reset after completion clears done and clock enable
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R12", {30'd0, cke, init_done}, 32'd0, 0);
    check("R12", {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7, 0);

    // R12: reset in the middle of the DLL lock wait restarts from the top
    rst = 1'b0;
    repeat (STAB + 20) @(posedge clk);
    @(negedge clk);
    check("R12", {31'd0, cke}, 32'd1, STAB + 20);
    run_case(VEC[0]);

    finished = 1'b1;
    summary();
  end

endmodule